// File: doc/BRIEF.md
# SIR Receive Deframing Filter

This block sits behind a slow-rate infrared UART receiver and strips the asynchronous framing from the decoded byte stream. It waits for a start flag, then passes on only the link-layer bytes (address, control, information and the trailing 16-bit FCS). Start and end flags, escape bytes and anything that arrives between frames are removed, and escaped bytes are restored. The payload leaves on a byte stream that marks the final byte of each frame.

Each payload byte is held for one byte time. This lets the last byte of a frame carry the end marker together with a one-cycle completion pulse and a four-bit status word. Status reports a frame cut short by a new start flag, a frame longer than the programmed limit, an escape followed directly by a flag, and (optionally) a bad FCS residue. A 12-bit counter shows how many bytes of the current frame have been stored. A receive gate blocks all input while reception is disabled, or while transmission is enabled without loopback.

Top module: `sir_deframer`

## Requirements
- R1: `flag_word` always reads 16'hC1C0: the start flag 0xC0 in bits [7:0] and the end flag 0xC1 in bits [15:8].
- R2: While no frame is open, every accepted byte other than 0xC0 (including 0xFF and 0xC1) is discarded and produces neither output nor a completion pulse.
- R3: Payload bytes between a start flag and an end flag leave on `out_byte` in arrival order, each one when the next payload byte is accepted. The final byte appears with `out_last`=1 and `frm_done`=1 in the cycle after the end flag is accepted.
- R4: Inside a frame, the escape byte 0x7D is removed and the byte after it is output XORed with 0x20.
- R5: An escape followed by 0xC0 or 0xC1 closes the frame with `frm_status` bit 2 set, and the block then ignores bytes until a new start flag.
- R6: A start flag inside a frame that holds at least one payload byte closes that frame with `frm_status` bit 0 set and opens a new frame at once. A start flag inside a frame with no payload yet simply restarts it without any report.
- R7: `byte_count` counts the payload bytes stored in the current frame. It reads 0 after an opening start flag and keeps its value after the frame ends.
- R8: Payload bytes beyond `cfg_max_len` are dropped (neither output nor counted), and the frame is closed with `frm_status` bit 1 set.
- R9: With `cfg_fcs_chk`=1, a frame closed by an end flag has `frm_status` bit 3 set exactly when the CRC-16 (reflected polynomial 0x8408, start value 0xFFFF) over payload plus FCS leaves a residue other than 0xF0B8. With `cfg_fcs_chk`=0, bit 3 is 0.
- R10: Bytes presented while `cfg_rx_en` & (!`cfg_tx_en` | `cfg_loop`) is 0 have no effect.
- R11: After reset, `out_valid`, `out_last`, `frm_done`, `frm_status` and `byte_count` are 0, and the block is waiting for a start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A decoded byte is present this cycle |
| in_byte | input | 8 | Decoded byte from the UART receiver |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_tx_en | input | 1 | Transmit enable (blocks receive unless loopback) |
| cfg_loop | input | 1 | Loopback mode |
| cfg_fcs_chk | input | 1 | Enable FCS residue check |
| cfg_max_len | input | 12 | Largest number of payload bytes stored per frame |
| out_valid | output | 1 | Payload byte valid |
| out_byte | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| frm_done | output | 1 | One-cycle frame completion pulse |
| frm_status | output | 4 | [0] missing end flag, [1] over length, [2] escape abort, [3] bad FCS |
| byte_count | output | 12 | Payload bytes stored in the current frame |
| flag_word | output | 16 | Fixed flag values {end, start} |

## Verification
A wrong framing state shows at the ports within one or two accepted bytes. A missed start flag leaves the following frame silent. A stuck escape state turns the next byte into an XORed value or a spurious escape abort on the next completion. An error in the hold register shifts or duplicates payload bytes and moves `out_last` away from the cycle after the end flag. A counter or CRC fault shows at the next completion, either as a wrong length flag or `byte_count` value or as an FCS flag that disagrees with a residue computed independently on the bench.

// File: rtl/sirdf_pkg.sv
package sirdf_pkg;

    localparam logic [7:0]  FLAG_OPEN  = 8'hC0;
    localparam logic [7:0]  FLAG_CLOSE = 8'hC1;
    localparam logic [7:0]  ESC_BYTE   = 8'h7D;
    localparam logic [7:0]  ESC_MASK   = 8'h20;
    localparam logic [15:0] CRC_SEED   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam logic [15:0] CRC_RESID  = 16'hF0B8;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_BODY,
        ST_ESC
    } uw_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_OPEN,
        EV_DATA,
        EV_CLOSE,
        EV_REOPEN,
        EV_ESCABORT
    } uw_event_e;

    typedef struct packed {
        logic crc_bad;    // bit 3
        logic esc_abort;  // bit 2
        logic len_over;   // bit 1
        logic no_close;   // bit 0
    } frm_stat_t;

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/sirdf_crc16.sv
module sirdf_crc16
    import sirdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed,
    input  logic        adv,
    input  logic [7:0]  data,
    output logic [15:0] crc,
    output logic        resid_ok
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (seed) begin
            crc_d = CRC_SEED;
        end else if (adv) begin
            crc_d = crc_byte(crc_q, data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc      = crc_q;
    assign resid_ok = (crc_q == CRC_RESID);

    // R9: a seed request always restarts the register
    a_r9_seed_restart: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (crc == CRC_SEED));

endmodule

// File: rtl/sirdf_unwrap.sv
module sirdf_unwrap
    import sirdf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic [7:0] byte_in,
    output uw_event_e  ev,
    output logic [7:0] data
);

    typedef struct packed {
        uw_state_e st;
        logic      has_data;
    } uw_reg_t;

    uw_reg_t d, q;

    always_comb begin
        d    = q;
        ev   = EV_NONE;
        data = byte_in;
        if (acc) begin
            unique case (q.st)
                ST_HUNT: begin
                    if (byte_in == FLAG_OPEN) begin
                        ev         = EV_OPEN;
                        d.st       = ST_BODY;
                        d.has_data = 1'b0;
                    end
                end
                ST_BODY: begin
                    if (byte_in == FLAG_OPEN) begin
                        ev         = q.has_data ? EV_REOPEN : EV_OPEN;
                        d.has_data = 1'b0;
                    end else if (byte_in == FLAG_CLOSE) begin
                        ev   = EV_CLOSE;
                        d.st = ST_HUNT;
                    end else if (byte_in == ESC_BYTE) begin
                        d.st = ST_ESC;
                    end else begin
                        ev         = EV_DATA;
                        d.has_data = 1'b1;
                    end
                end
                ST_ESC: begin
                    if (byte_in == FLAG_OPEN || byte_in == FLAG_CLOSE) begin
                        ev   = EV_ESCABORT;
                        d.st = ST_HUNT;
                    end else begin
                        ev         = EV_DATA;
                        data       = byte_in ^ ESC_MASK;
                        d.has_data = 1'b1;
                        d.st       = ST_BODY;
                    end
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_HUNT, has_data: 1'b0};
        else        q <= d;
    end

    // R4: an escape inside a frame always parks the walker in the escape state
    a_r4_escape_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && byte_in == ESC_BYTE && q.st == ST_BODY) |=> (q.st == ST_ESC));

    // R2: while hunting only an opening flag can produce an event
    a_r2_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HUNT) |-> (ev == EV_NONE || ev == EV_OPEN));

    // R5: an aborted escape returns to hunting
    a_r5_abort_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_ESCABORT) |=> (q.st == ST_HUNT));

endmodule

// File: rtl/sir_deframer.sv
module sir_deframer
    import sirdf_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             cfg_rx_en,
    input  logic             cfg_tx_en,
    input  logic             cfg_loop,
    input  logic             cfg_fcs_chk,
    input  logic [LEN_W-1:0] cfg_max_len,
    output logic             out_valid,
    output logic [7:0]       out_byte,
    output logic             out_last,
    output logic             frm_done,
    output logic [3:0]       frm_status,
    output logic [LEN_W-1:0] byte_count,
    output logic [15:0]      flag_word
);

    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    typedef struct packed {
        logic [7:0]       hold;
        logic             hold_vld;
        logic [LEN_W-1:0] cnt;
        logic             len_over;
        logic             o_vld;
        logic [7:0]       o_byte;
        logic             o_last;
        logic             o_done;
        frm_stat_t        o_stat;
    } df_reg_t;

    df_reg_t d, q;

    logic       rx_gate;
    logic       acc;
    uw_event_e  ev;
    logic [7:0] uw_data;
    logic       crc_seed;
    logic       crc_adv;
    logic [15:0] crc_val;
    logic       crc_ok;

    assign rx_gate = cfg_rx_en & (~cfg_tx_en | cfg_loop);
    assign acc     = in_valid & rx_gate;

    sirdf_unwrap u_unwrap (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .byte_in (in_byte),
        .ev      (ev),
        .data    (uw_data)
    );

    assign crc_seed = (ev == EV_OPEN) || (ev == EV_REOPEN);
    assign crc_adv  = (ev == EV_DATA);

    sirdf_crc16 u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed     (crc_seed),
        .adv      (crc_adv),
        .data     (uw_data),
        .crc      (crc_val),
        .resid_ok (crc_ok)
    );

    always_comb begin
        d        = q;
        d.o_vld  = 1'b0;
        d.o_last = 1'b0;
        d.o_done = 1'b0;
        unique case (ev)
            EV_OPEN: begin
                d.cnt      = '0;
                d.len_over = 1'b0;
                d.hold_vld = 1'b0;
            end
            EV_DATA: begin
                if (q.cnt < cfg_max_len) begin
                    if (q.hold_vld) begin
                        d.o_vld  = 1'b1;
                        d.o_byte = q.hold;
                    end
                    d.hold     = uw_data;
                    d.hold_vld = 1'b1;
                    d.cnt      = q.cnt + CNT_ONE;
                end else begin
                    d.len_over = 1'b1;
                end
            end
            EV_CLOSE, EV_REOPEN, EV_ESCABORT: begin
                if (q.hold_vld) begin
                    d.o_vld  = 1'b1;
                    d.o_byte = q.hold;
                    d.o_last = 1'b1;
                end
                d.hold_vld        = 1'b0;
                d.o_done          = 1'b1;
                d.o_stat          = '0;
                d.o_stat.len_over = q.len_over;
                if (ev == EV_CLOSE) begin
                    d.o_stat.crc_bad = cfg_fcs_chk & ~crc_ok;
                end else if (ev == EV_REOPEN) begin
                    d.o_stat.no_close = 1'b1;
                    d.cnt             = '0;
                    d.len_over        = 1'b0;
                end else begin
                    d.o_stat.esc_abort = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid  = q.o_vld;
    assign out_byte   = q.o_byte;
    assign out_last   = q.o_last;
    assign frm_done   = q.o_done;
    assign frm_status = q.o_stat;
    assign byte_count = q.cnt;
    assign flag_word  = {FLAG_CLOSE, FLAG_OPEN};

    // R10: a cycle without an accepted byte yields no output next cycle
    a_r10_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!out_valid && !frm_done));

    // R7: opening a frame clears the stored-byte count
    a_r7_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_OPEN || ev == EV_REOPEN) |=> (byte_count == '0));

    // R8: the count never grows past the limit in force
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count <= cfg_max_len) |=> (byte_count <= $past(cfg_max_len)));

    // R3: the end marker travels only with a completion pulse
    a_r3_last_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && frm_done));

    // R6: the three closing causes never coincide
    a_r6_cause_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> $onehot0({frm_status[3], frm_status[2], frm_status[0]}));

    // R9: with the check off no FCS error is reported
    a_r9_check_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_fcs_chk |=> (!frm_done || !frm_status[3]));

endmodule

// File: tb/sim_sir_deframer.sv
`timescale 1ns/1ps
module sim_sir_deframer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        cfg_rx_en = 1'b1;
    logic        cfg_tx_en = 1'b0;
    logic        cfg_loop = 1'b0;
    logic        cfg_fcs_chk = 1'b0;
    logic [11:0] cfg_max_len = 12'd16;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        out_last;
    logic        frm_done;
    logic [3:0]  frm_status;
    logic [11:0] byte_count;
    logic [15:0] flag_word;

    int nchk = 0;
    int nfail = 0;
    int nout = 0;
    int ndone = 0;
    logic [7:0] lastb = 8'h00;
    logic [3:0] lstat = 4'h0;
    logic       lastlast = 1'b0;

    always #2.5 clk = ~clk;

    sir_deframer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_rx_en(cfg_rx_en), .cfg_tx_en(cfg_tx_en), .cfg_loop(cfg_loop),
        .cfg_fcs_chk(cfg_fcs_chk), .cfg_max_len(cfg_max_len),
        .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
        .frm_done(frm_done), .frm_status(frm_status), .byte_count(byte_count),
        .flag_word(flag_word)
    );

    // {in_byte, exp_valid, exp_byte, exp_last, exp_done, exp_status}
    localparam logic [22:0] TBL [0:16] = '{
        {8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},  // R2
        {8'hC1, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},  // R2
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'h22, 1'b1, 8'h11, 1'b0, 1'b0, 4'h0},  // R3
        {8'h7D, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'h5E, 1'b1, 8'h22, 1'b0, 1'b0, 4'h0},  // R4
        {8'hC1, 1'b1, 8'h7E, 1'b1, 1'b1, 4'h0},  // R3 R4
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'hC0, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},  // R6 silent restart
        {8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'hC0, 1'b1, 8'h33, 1'b1, 1'b1, 4'h1},  // R6
        {8'h44, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'h7D, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},
        {8'hC1, 1'b1, 8'h44, 1'b1, 1'b1, 4'h4},  // R5
        {8'h55, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0},  // R5 hunting
        {8'hC1, 1'b0, 8'h00, 1'b0, 1'b0, 4'h0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with outputs sampled
    task automatic step(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        if (out_valid) begin
            nout++;
            lastb = out_byte;
        end
        if (frm_done) begin
            ndone++;
            lstat    = frm_status;
            lastlast = out_last;
        end
    endtask

    task automatic send_esc(input logic [7:0] b);
        if (b == 8'hC0 || b == 8'hC1 || b == 8'h7D) begin
            step(8'h7D);
            step(b ^ 8'h20);
        end else begin
            step(b);
        end
    endtask

    task automatic clr_mon();
        nout = 0;
        ndone = 0;
        lstat = 4'h0;
        lastlast = 1'b0;
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'h8408;
            else      r = r >> 1;
        end
        return r;
    endfunction

    task automatic send_fcs_frame(input logic [15:0] corrupt);
        logic [7:0]  pl [4];
        logic [15:0] c;
        logic [15:0] fcs;
        pl[0] = 8'h03; pl[1] = 8'h3F; pl[2] = 8'h11; pl[3] = 8'h22;
        c = 16'hFFFF;
        for (int k = 0; k < 4; k++) c = ref_crc(c, pl[k]);
        fcs = ~c ^ corrupt;
        step(8'hC0);
        for (int k = 0; k < 4; k++) send_esc(pl[k]);
        send_esc(fcs[7:0]);
        send_esc(fcs[15:8]);
        step(8'hC1);
    endtask

    initial begin
        #1000000;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 / R1 reset state
        chk(out_valid == 1'b0 && out_last == 1'b0 && frm_done == 1'b0, "R11 outputs idle", {out_valid, out_last, frm_done}, 0);
        chk(frm_status == 4'h0 && byte_count == 12'd0, "R11 status and count", {frm_status, byte_count}, 0);
        chk(flag_word == 16'hC1C0, "R1 flag word", flag_word, 16'hC1C0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flag_word == 16'hC1C0, "R1 flag word after reset", flag_word, 16'hC1C0);

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 17; i++) begin
            logic [22:0] row;
            logic [14:0] act;
            row = TBL[i];
            step(row[22:15]);
            act = {out_valid, out_valid ? out_byte : 8'h00, out_last, frm_done, frm_done ? frm_status : 4'h0};
            chk(act == row[14:0], $sformatf("R2/R3/R4/R5/R6 table row %0d", i), act, row[14:0]);
        end

        // R7 counter
        step(8'hC0);
        chk(byte_count == 12'd0, "R7 count cleared by start flag", byte_count, 0);
        step(8'h01); step(8'h02); step(8'h03);
        chk(byte_count == 12'd3, "R7 count of stored bytes", byte_count, 3);
        step(8'hC1);
        chk(byte_count == 12'd3, "R7 count held after end", byte_count, 3);

        // R8 length limit
        cfg_max_len = 12'd2;
        clr_mon();
        step(8'hC0); step(8'h0A); step(8'h0B); step(8'h0C); step(8'h0D); step(8'hC1);
        chk(nout == 2, "R8 bytes beyond limit dropped", nout, 2);
        chk(lastb == 8'h0B && lastlast == 1'b1, "R8 last stored byte", lastb, 8'h0B);
        chk(ndone == 1 && lstat == 4'h2, "R8 length status", lstat, 4'h2);
        chk(byte_count == 12'd2, "R8 count stops at limit", byte_count, 2);
        cfg_max_len = 12'd16;

        // R9 FCS check
        cfg_fcs_chk = 1'b1;
        clr_mon();
        send_fcs_frame(16'h0000);
        chk(ndone == 1 && lstat == 4'h0, "R9 good FCS", lstat, 4'h0);
        chk(nout == 6, "R9 payload plus FCS delivered", nout, 6);
        clr_mon();
        send_fcs_frame(16'h0001);
        chk(ndone == 1 && lstat == 4'h8, "R9 bad FCS flagged", lstat, 4'h8);
        cfg_fcs_chk = 1'b0;
        clr_mon();
        send_fcs_frame(16'h0001);
        chk(ndone == 1 && lstat == 4'h0, "R9 check disabled", lstat, 4'h0);

        // R10 receive gate
        cfg_tx_en = 1'b1;
        clr_mon();
        step(8'hC0); step(8'h11); step(8'h22); step(8'hC1);
        chk(nout == 0 && ndone == 0, "R10 transmit without loopback blocks", {nout[15:0], ndone[15:0]}, 0);
        cfg_loop = 1'b1;
        clr_mon();
        step(8'hC0); step(8'h11); step(8'h22); step(8'hC1);
        chk(nout == 2 && ndone == 1, "R10 loopback lets bytes in", {nout[15:0], ndone[15:0]}, {16'd2, 16'd1});
        cfg_tx_en = 1'b0;
        cfg_loop = 1'b0;
        cfg_rx_en = 1'b0;
        clr_mon();
        step(8'hC0); step(8'h11); step(8'hC1);
        chk(nout == 0 && ndone == 0 && byte_count == 12'd2, "R10 receive disabled", {nout[15:0], ndone[15:0]}, 0);
        cfg_rx_en = 1'b1;

        // R11 reset in mid frame returns to hunting
        step(8'hC0); step(8'h77);
        rst_n = 1'b0;
        @(negedge clk);
        chk(byte_count == 12'd0 && out_valid == 1'b0, "R11 reset clears", byte_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        clr_mon();
        step(8'h44); step(8'hC1);
        chk(nout == 0 && ndone == 0, "R11 hunting after reset", {nout[15:0], ndone[15:0]}, 0);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule